// File: doc/BRIEF.md
# Printer handshake protocol adapter

This block joins a host parallel port that waits on a level busy signal to a peripheral that only answers with an acknowledge pulse. Each time the host pulses its data strobe, the adapter raises busy. It holds busy until the peripheral acknowledges, then drops it. The host therefore sees an ordinary busy handshake, although the peripheral never produces one. The data bus goes straight from host to peripheral and does not pass through the block.

The strobe and acknowledge inputs are brought to the system clock through two-flop synchronisers. Their asserting edges are then detected inside the block.

The strobe is active low by default; the `STB_ACTIVE_LOW` parameter sets this. The acknowledge polarity and the busy polarity are chosen at run time with two select pins, because equipment differs on whether these two lines are inverted. The peripheral's own busy line and the host's own acknowledge line play no part in the scheme, so the block has no ports for them.

The core is a two-state machine:
- State IDLE moves to state BUSY on the transition STROBE_SEEN, which is a strobe asserting edge.
- State BUSY moves back to IDLE on the transition ACK_SEEN, which is an acknowledge asserting edge in a cycle with no strobe edge.
- Every other case is the transition HOLD, which keeps the current state. This covers an acknowledge in IDLE, a strobe in BUSY, and a strobe and an acknowledge in the same cycle while in BUSY.

Top module: `prn_hs_adapter`

## Requirements
- R1: While reset is asserted and after it is released, busy is deasserted: `busy_out` equals `busy_pol`.
- R2: An asserting edge of the strobe sets busy. With `STB_ACTIVE_LOW`=1 this edge is a 1-to-0 change of `strobe_raw`. `busy_out` changes on the third rising clock edge after the input change and keeps its old value after the second.
- R3: In BUSY, an asserting edge of the acknowledge clears busy, with the same three-edge latency as R2.
- R4: Only the strobe edge sets busy. A strobe held asserted through and after an acknowledge does not re-set busy.
- R5: An acknowledge in IDLE has no effect. Busy stays deasserted, and a later strobe still sets busy.
- R6: With `ack_pol`=0 the acknowledge is active when `ack_raw` is high. With `ack_pol`=1 it is active when `ack_raw` is low.
- R7: With `busy_pol`=0, `busy_out` is high when busy. With `busy_pol`=1, `busy_out` is low when busy. A change of `busy_pol` reaches `busy_out` without a clock edge.
- R8: When a strobe edge and an acknowledge edge occur in the same cycle, busy ends up asserted, whether the state was IDLE or BUSY.
- R9: Further strobe edges while in BUSY keep busy asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_raw | input | 1 | Host data strobe, asynchronous |
| ack_raw | input | 1 | Peripheral acknowledge, asynchronous |
| ack_pol | input | 1 | 0: acknowledge active high; 1: active low |
| busy_pol | input | 1 | 0: busy driven high when set; 1: driven low |
| busy_out | output | 1 | Busy level to the host |

## Verification
The bench holds the strobe asserted across an acknowledge. A design that detects the strobe by level rather than by edge would raise busy again at once.

It also asserts the strobe and the acknowledge in the same cycle, both from IDLE and from BUSY. A design in which clear wins would leave busy low and lose a character.

An acknowledge is sent while the block is idle, and both polarity selects are changed. A latch that does not ignore a stray acknowledge, or an inversion on the wrong side, shows up as a wrong busy level.

The exact latency is probed on both sides of the third edge. A missing or extra synchroniser stage shifts the change by one cycle.

// File: rtl/hs_pkg.sv
package hs_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_BUSY = 1'b1
    } hs_state_e;
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_edge.sv
module hs_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic rise
);
    logic prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev <= 1'b0;
        end else begin
            prev <= lvl;
        end
    end

    assign rise = lvl & ~prev;
endmodule

// File: rtl/hs_fsm.sv
module hs_fsm
    import hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic stb_rise,
    input  logic ack_rise,
    output logic busy_lvl
);
    hs_state_e state, state_nx;

    // Next-state logic: STROBE_SEEN, ACK_SEEN, HOLD
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE: begin
                if (stb_rise) begin
                    state_nx = S_BUSY;              // STROBE_SEEN
                end
            end
            S_BUSY: begin
                if (ack_rise && !stb_rise) begin
                    state_nx = S_IDLE;              // ACK_SEEN (set wins a tie)
                end
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_lvl <= 1'b0;
        end else begin
            busy_lvl <= (state_nx == S_BUSY);
        end
    end
endmodule

// File: rtl/prn_hs_adapter.sv
module prn_hs_adapter #(
    parameter bit STB_ACTIVE_LOW = 1'b1,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_raw,
    input  logic ack_raw,
    input  logic ack_pol,
    input  logic busy_pol,
    output logic busy_out
);
    localparam logic STB_FLIP = STB_ACTIVE_LOW;

    logic stb_norm, ack_norm;
    logic stb_sync, ack_sync;
    logic stb_rise, ack_rise;
    logic busy_lvl;

    // Normalise to active-high so the synchroniser reset value means idle
    assign stb_norm = strobe_raw ^ STB_FLIP;
    assign ack_norm = ack_raw ^ ack_pol;

    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_stb (
        .clk(clk), .rst_n(rst_n), .d(stb_norm), .q(stb_sync)
    );
    hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (
        .clk(clk), .rst_n(rst_n), .d(ack_norm), .q(ack_sync)
    );

    hs_edge u_edge_stb (.clk(clk), .rst_n(rst_n), .lvl(stb_sync), .rise(stb_rise));
    hs_edge u_edge_ack (.clk(clk), .rst_n(rst_n), .lvl(ack_sync), .rise(ack_rise));

    hs_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .stb_rise(stb_rise), .ack_rise(ack_rise),
        .busy_lvl(busy_lvl)
    );

    assign busy_out = busy_lvl ^ busy_pol;
endmodule

// File: rtl/hs_checker.sv
module hs_checker (
    input logic clk,
    input logic rst_n,
    input logic stb_rise,
    input logic ack_rise,
    input logic busy_lvl,
    input logic busy_pol,
    input logic busy_out
);
    // R1: reset holds busy low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_r1_reset_idle: assert (!busy_lvl && busy_out == busy_pol)
                else $error("a_r1_reset_idle");
        end
    end

    // R2: a strobe edge sets busy next cycle
    a_r2_strobe_sets: assert property (@(posedge clk) disable iff (!rst_n)
        stb_rise |=> busy_lvl);

    // R3: an acknowledge without a strobe clears busy
    a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_lvl && ack_rise && !stb_rise) |=> !busy_lvl);

    // R4, R5: without a strobe edge busy never rises
    a_r4_no_level_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_lvl && !stb_rise) |=> !busy_lvl);

    // R9: busy only falls on an acknowledge
    a_r9_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_lvl && !ack_rise) |=> busy_lvl);

    // R8: set wins a tie
    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_rise && ack_rise) |=> busy_lvl);

    // R7: output level follows the polarity select
    a_r7_busy_pol: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_lvl) && $stable(busy_pol)) |-> (busy_out == !busy_pol));
endmodule

bind prn_hs_adapter hs_checker u_chk (
    .clk(clk), .rst_n(rst_n),
    .stb_rise(stb_rise), .ack_rise(ack_rise),
    .busy_lvl(busy_lvl), .busy_pol(busy_pol), .busy_out(busy_out)
);

// File: tb/tb_prn_hs_adapter.sv
module tb_prn_hs_adapter;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic  exp;
        string tag;
    } sb_item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_raw = 1'b1;
    logic ack_raw = 1'b0;
    logic ack_pol = 1'b0;
    logic busy_pol = 1'b0;
    logic busy_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    sb_item_t sbq[$];

    prn_hs_adapter dut (
        .clk(clk), .rst_n(rst_n),
        .strobe_raw(strobe_raw), .ack_raw(ack_raw),
        .ack_pol(ack_pol), .busy_pol(busy_pol),
        .busy_out(busy_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Monitor: pops expected items and compares them with the output
    initial begin
        sb_item_t it;
        forever begin
            wait (sbq.size() != 0);
            it = sbq.pop_front();
            checks++;
            if (busy_out !== it.exp) begin
                errors++;
                $display("FAIL %s: busy_out=%b expected=%b", it.tag, busy_out, it.exp);
            end
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic expect_out(input logic v, input string tag);
        sb_item_t it;
        it.exp = v;
        it.tag = tag;
        sbq.push_back(it);
        #1;
    endtask

    task automatic pulse_stb();
        strobe_raw = 1'b0;
        cyc(2);
        strobe_raw = 1'b1;
        cyc(4);
    endtask

    task automatic pulse_ack();
        ack_raw = !ack_pol;
        cyc(2);
        ack_raw = ack_pol;
        cyc(4);
    endtask

    initial begin
        cyc(3);
        expect_out(1'b0, "R1 in reset");
        rst_n = 1'b1;
        cyc(3);
        expect_out(1'b0, "R1 after reset");

        // R2 latency
        strobe_raw = 1'b0;
        cyc(2);
        expect_out(1'b0, "R2 before third edge");
        cyc(1);
        expect_out(1'b1, "R2 set");
        strobe_raw = 1'b1;
        cyc(3);

        // R3 latency
        ack_raw = 1'b1;
        cyc(2);
        expect_out(1'b1, "R3 before third edge");
        cyc(1);
        expect_out(1'b0, "R3 cleared");
        ack_raw = 1'b0;
        cyc(3);

        // R4 long strobe
        strobe_raw = 1'b0;
        cyc(4);
        expect_out(1'b1, "R4 set by held strobe");
        pulse_ack();
        expect_out(1'b0, "R4 cleared under held strobe");
        cyc(6);
        expect_out(1'b0, "R4 no re-set from level");
        strobe_raw = 1'b1;
        cyc(4);
        expect_out(1'b0, "R4 strobe release");

        // R5 stray acknowledge
        pulse_ack();
        expect_out(1'b0, "R5 ack in idle");
        pulse_stb();
        expect_out(1'b1, "R5 strobe after stray ack");
        pulse_ack();
        expect_out(1'b0, "R5 clear");

        // R9 repeated strobes
        pulse_stb();
        expect_out(1'b1, "R9 first strobe");
        pulse_stb();
        expect_out(1'b1, "R9 second strobe");
        pulse_ack();
        expect_out(1'b0, "R9 clear");

        // R8 tie from IDLE and from BUSY
        strobe_raw = 1'b0;
        ack_raw = 1'b1;
        cyc(4);
        expect_out(1'b1, "R8 tie from idle");
        strobe_raw = 1'b1;
        ack_raw = 1'b0;
        cyc(4);
        strobe_raw = 1'b0;
        ack_raw = 1'b1;
        cyc(4);
        expect_out(1'b1, "R8 tie from busy");
        strobe_raw = 1'b1;
        ack_raw = 1'b0;
        cyc(4);
        pulse_ack();
        expect_out(1'b0, "R8 clear");

        // R6 active-low acknowledge
        ack_pol = 1'b1;
        ack_raw = 1'b1;
        cyc(4);
        expect_out(1'b0, "R6 pol switch no effect");
        pulse_stb();
        expect_out(1'b1, "R6 set");
        cyc(4);
        expect_out(1'b1, "R6 high ack idle when active low");
        ack_raw = 1'b0;
        cyc(4);
        expect_out(1'b0, "R6 low ack clears");
        ack_raw = 1'b1;
        cyc(4);

        // R7 active-low busy
        busy_pol = 1'b1;
        expect_out(1'b1, "R7 idle reads high");
        pulse_stb();
        expect_out(1'b0, "R7 busy reads low");
        busy_pol = 1'b0;
        expect_out(1'b1, "R7 pol change immediate");
        busy_pol = 1'b1;
        pulse_ack();
        expect_out(1'b1, "R7 cleared reads high");

        cyc(2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule